// File: doc/BRIEF.md
# Hardware Context Swap Unit for Single-Level Interrupts

This unit sits next to the register file and the fetch logic of a small in-order core. It lets a handler written as an ordinary compiled function run without any context save in software. An interrupt source offers a handler address over a valid/ready handshake. The unit accepts it only while the core is in its fetch stage and no handler is already running.

In the cycle it accepts, the unit does three things. It snapshots the next fetch address and the five compiler-managed registers into private copies. It points the fetch logic at the handler. It raises its busy flag.

A decoded return-from-interrupt strobe ends the handler. In that cycle the unit presents all saved register values for write-back and sends fetch back to the saved address. It then drops the busy flag.

The handler is free to clobber the live return-address register with nested calls, because the copy that is restored is private to this unit.

Back-pressure rule: a source that raises `irq_valid` must hold it, with `irq_handler` unchanged, until it sees `irq_ready` high in the same cycle. A transfer happens on any rising edge where both are high. `irq_ready` never depends on `irq_valid`.

Top module: `irq_ctx_unit`

## Requirements
- R1: After reset, `in_service` is 0, and both `redirect_valid` and `restore_valid` stay 0 while `irq_valid` is held low.
- R2: `irq_ready` is 1 exactly when `fetch_stage` is 1 and `in_service` is 0.
- R3: In a cycle where `irq_valid` and `irq_ready` are both 1, `redirect_valid` is 1 and `redirect_addr` equals `irq_handler`.
- R4: `in_service` is 1 in the cycle after a transfer. It is 0 in the cycle after a cycle in which `uret_strobe` and `in_service` were both 1. Otherwise it keeps its value.
- R5: In a cycle where `uret_strobe` and `in_service` are both 1, `restore_valid` and `redirect_valid` are 1, and `redirect_addr` equals `live_pc_next` as sampled at the transfer. `restore_sp`, `restore_fp`, `restore_ra`, `restore_tp` and `restore_gp` equal their `live_*` counterparts as sampled at the transfer.
- R6: `uret_strobe` while `in_service` is 0 has no effect: `restore_valid` and `redirect_valid` stay 0 and `in_service` stays 0.
- R7: While `in_service` is 1, no request is accepted. A held request is taken in the first cycle that has `fetch_stage` high and `in_service` low, and this includes the case where `fetch_stage` was low when the request arrived.
- R8: Changes to any `live_*` input between a transfer and the following restore do not alter the restored values.
- R9: `redirect_valid` is 1 only in a transfer cycle or a restore cycle, and `restore_valid` is 1 only in a restore cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | Interrupt request offered |
| irq_ready | output | 1 | Unit can take a request this cycle |
| irq_handler | input | XLEN | Handler entry address |
| fetch_stage | input | 1 | Core controller is in its fetch stage |
| uret_strobe | input | 1 | Return-from-interrupt decoded this cycle |
| live_pc_next | input | XLEN | Address of the instruction to be fetched next |
| live_sp | input | XLEN | Live stack pointer |
| live_fp | input | XLEN | Live frame pointer |
| live_ra | input | XLEN | Live return address |
| live_tp | input | XLEN | Live thread pointer |
| live_gp | input | XLEN | Live global pointer |
| redirect_valid | output | 1 | Fetch must jump to redirect_addr |
| redirect_addr | output | XLEN | Handler address on entry, saved PC on return |
| restore_valid | output | 1 | Write restore_* back to the register file |
| restore_sp | output | XLEN | Saved stack pointer |
| restore_fp | output | XLEN | Saved frame pointer |
| restore_ra | output | XLEN | Saved return address |
| restore_tp | output | XLEN | Saved thread pointer |
| restore_gp | output | XLEN | Saved global pointer |
| in_service | output | 1 | A handler is running |

## Verification
The embedded assertions check the rules that hold on every cycle. These are:
- the busy flag sets after a transfer and clears after an effective return;
- `irq_ready` is never high while busy;
- the saved copies hold steady except in a transfer cycle, and match the live inputs of the transfer cycle;
- entry and return never coincide.

Only the bench's scenarios can show the end-to-end behaviours. One is a request held through a busy period or a non-fetch period and then taken at exactly the right cycle. Another is that all six values come back intact after the handler has overwritten the live registers. The last is that a stray return while idle leaves nothing changed.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  // Slot order inside the saved-context bank.
  typedef enum int unsigned {
    SLOT_PC = 0,
    SLOT_SP = 1,
    SLOT_FP = 2,
    SLOT_RA = 3,
    SLOT_TP = 4,
    SLOT_GP = 5
  } ctx_slot_e;

  localparam int unsigned NUM_SLOTS = 6;

endpackage

// File: rtl/irq_ctx_gate.sv
// Acceptance logic and the single-level busy flag.
module irq_ctx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fetch_stage,
  input  logic uret_strobe,
  output logic req_ready,
  output logic take,
  output logic give_back,
  output logic busy
);

  assign req_ready = fetch_stage & ~busy;
  assign take      = req_valid & req_ready;
  assign give_back = uret_strobe & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (take) begin
      busy <= 1'b1;
    end else if (give_back) begin
      busy <= 1'b0;
    end
  end

  // R4: entry sets the flag
  p_set_on_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

  // R4: effective return clears the flag
  p_clear_on_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    give_back |=> !busy);

  // R6: stray return while idle keeps the unit idle
  p_stray_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && uret_strobe && !req_valid) |=> !busy);

  // R7: nothing can be accepted while busy
  p_no_take_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R4: flag only rises after a request in fetch stage
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && fetch_stage));

endmodule

// File: rtl/irq_ctx_shadow.sv
// Private bank holding the interrupted context.
module irq_ctx_shadow #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SLOTS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [SLOTS-1:0][XLEN-1:0] live_ctx,
  output logic [SLOTS-1:0][XLEN-1:0] saved_ctx
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        saved_ctx[s] <= '0;
      end else if (capture) begin
        saved_ctx[s] <= live_ctx[s];
      end
    end
  end

  // R8: saved copies are immune to live changes outside entry
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(saved_ctx));

  // R5: entry snapshots every live value
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (saved_ctx == $past(live_ctx)));

endmodule

// File: rtl/irq_ctx_unit.sv
// Single-level interrupt entry/return with hardware context swap.
module irq_ctx_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_valid,
  output logic            irq_ready,
  input  logic [XLEN-1:0] irq_handler,
  input  logic            fetch_stage,
  input  logic            uret_strobe,
  input  logic [XLEN-1:0] live_pc_next,
  input  logic [XLEN-1:0] live_sp,
  input  logic [XLEN-1:0] live_fp,
  input  logic [XLEN-1:0] live_ra,
  input  logic [XLEN-1:0] live_tp,
  input  logic [XLEN-1:0] live_gp,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_addr,
  output logic            restore_valid,
  output logic [XLEN-1:0] restore_sp,
  output logic [XLEN-1:0] restore_fp,
  output logic [XLEN-1:0] restore_ra,
  output logic [XLEN-1:0] restore_tp,
  output logic [XLEN-1:0] restore_gp,
  output logic            in_service
);
  import irq_ctx_pkg::*;

  localparam int unsigned SLOTS = NUM_SLOTS;

  logic                       take;
  logic                       give_back;
  logic [SLOTS-1:0][XLEN-1:0] live_ctx;
  logic [SLOTS-1:0][XLEN-1:0] saved_ctx;

  always_comb begin
    live_ctx          = '0;
    live_ctx[SLOT_PC] = live_pc_next;
    live_ctx[SLOT_SP] = live_sp;
    live_ctx[SLOT_FP] = live_fp;
    live_ctx[SLOT_RA] = live_ra;
    live_ctx[SLOT_TP] = live_tp;
    live_ctx[SLOT_GP] = live_gp;
  end

  irq_ctx_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (irq_valid),
    .fetch_stage (fetch_stage),
    .uret_strobe (uret_strobe),
    .req_ready   (irq_ready),
    .take        (take),
    .give_back   (give_back),
    .busy        (in_service)
  );

  irq_ctx_shadow #(
    .XLEN  (XLEN),
    .SLOTS (SLOTS)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (take),
    .live_ctx  (live_ctx),
    .saved_ctx (saved_ctx)
  );

  assign redirect_valid = take | give_back;
  assign redirect_addr  = take ? irq_handler : saved_ctx[SLOT_PC];
  assign restore_valid  = give_back;
  assign restore_sp     = saved_ctx[SLOT_SP];
  assign restore_fp     = saved_ctx[SLOT_FP];
  assign restore_ra     = saved_ctx[SLOT_RA];
  assign restore_tp     = saved_ctx[SLOT_TP];
  assign restore_gp     = saved_ctx[SLOT_GP];

  // R9: entry and return never share a cycle
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && give_back));

  // R5: a restore is only offered while a handler is running
  p_restore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> in_service);

endmodule

// File: tb/irq_ctx_unit_bench.sv
module irq_ctx_unit_bench;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_valid = 1'b0;
  logic irq_ready;
  logic [XLEN-1:0] irq_handler = '0;
  logic fetch_stage = 1'b0;
  logic uret_strobe = 1'b0;
  logic [XLEN-1:0] live_pc_next = '0, live_sp = '0, live_fp = '0;
  logic [XLEN-1:0] live_ra = '0, live_tp = '0, live_gp = '0;
  logic redirect_valid, restore_valid, in_service;
  logic [XLEN-1:0] redirect_addr, restore_sp, restore_fp, restore_ra, restore_tp, restore_gp;

  int total = 0;
  int fails = 0;

  // bench model state
  logic            m_busy = 1'b0;
  logic            m_pend = 1'b0;
  logic [XLEN-1:0] m_hand = '0;
  logic [XLEN-1:0] m_save [6];

  always #5 clk = ~clk;

  irq_ctx_unit #(.XLEN(XLEN)) u_irq_ctx_unit (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_handler(irq_handler), .fetch_stage(fetch_stage), .uret_strobe(uret_strobe),
    .live_pc_next(live_pc_next), .live_sp(live_sp), .live_fp(live_fp),
    .live_ra(live_ra), .live_tp(live_tp), .live_gp(live_gp),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .restore_valid(restore_valid), .restore_sp(restore_sp), .restore_fp(restore_fp),
    .restore_ra(restore_ra), .restore_tp(restore_tp), .restore_gp(restore_gp),
    .in_service(in_service)
  );

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_ready(logic f, logic b);
    return f & ~b;
  endfunction

  // One cycle: drive after negedge, check before posedge, advance model.
  task automatic step(logic f, logic u, logic new_req);
    logic acc, ret;
    @(negedge clk);
    if (new_req && !m_pend) begin
      m_pend = 1'b1;
      m_hand = $urandom() & 32'hFFFF_FFFC;
    end
    fetch_stage  = f;
    uret_strobe  = u;
    irq_valid    = m_pend;
    irq_handler  = m_pend ? m_hand : $urandom();
    live_pc_next = $urandom();
    live_sp = $urandom(); live_fp = $urandom(); live_ra = $urandom();
    live_tp = $urandom(); live_gp = $urandom();
    #2;
    acc = m_pend & exp_ready(f, m_busy);
    ret = u & m_busy;
    chk("R4 in_service", {31'd0, in_service}, {31'd0, m_busy});
    chk("R2 irq_ready", {31'd0, irq_ready}, {31'd0, exp_ready(f, m_busy)});
    if (m_busy) chk("R7 ready low while busy", {31'd0, irq_ready}, 32'd0);
    chk("R9 redirect_valid", {31'd0, redirect_valid}, {31'd0, acc | ret});
    chk("R9 restore_valid", {31'd0, restore_valid}, {31'd0, ret});
    if (u && !m_busy) chk("R6 stray return no restore", {31'd0, restore_valid}, 32'd0);
    if (acc) chk("R3 redirect to handler", redirect_addr, m_hand);
    if (ret) begin
      chk("R5 redirect to saved pc", redirect_addr, m_save[0]);
      chk("R5/R8 sp", restore_sp, m_save[1]);
      chk("R5/R8 fp", restore_fp, m_save[2]);
      chk("R5/R8 ra", restore_ra, m_save[3]);
      chk("R5/R8 tp", restore_tp, m_save[4]);
      chk("R5/R8 gp", restore_gp, m_save[5]);
    end
    if (acc) begin
      m_save[0] = live_pc_next; m_save[1] = live_sp; m_save[2] = live_fp;
      m_save[3] = live_ra; m_save[4] = live_tp; m_save[5] = live_gp;
      m_busy = 1'b1;
      m_pend = 1'b0;
    end else if (ret) begin
      m_busy = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_save[i] = '0;
    void'($urandom(32'd1234));
    // R1: reset state
    fetch_stage = 1'b1; uret_strobe = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 in_service", {31'd0, in_service}, 32'd0);
    chk("R1 restore_valid", {31'd0, restore_valid}, 32'd0);
    chk("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R6: stray returns while idle
    step(1, 1, 0); step(0, 1, 0); step(1, 0, 0);
    chk("R6 still idle", {31'd0, in_service}, 32'd0);

    // R7: request outside fetch stage waits, then taken
    step(0, 0, 1); step(0, 0, 0); step(1, 0, 0);
    // handler runs, clobbers live registers (R8), new request held while busy (R7)
    step(1, 0, 0); step(1, 0, 1); step(0, 0, 0); step(1, 0, 0);
    step(1, 1, 0);   // return
    step(1, 0, 0);   // held request taken here
    step(1, 1, 0);   // return
    step(0, 1, 0);   // stray

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom() % 3) != 0, ($urandom() % 5) == 0, ($urandom() % 4) == 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule